// File: doc/BRIEF.md
# Dual-Output Vectored Interrupt Controller

This block gathers 64 level-driven interrupt sources and drives two requests toward a processor: a normal request and a fast request. Each source has a pending bit, an enable bit and a type bit. The type bit routes the source to the fast request (1) or to the normal path (0). A normal request is raised only when a pending, enabled, normal source has a 4-bit priority above the programmed mask. A child arbiter makes that priority selection. A second child finds the lowest-numbered fast source.

Software uses a single-strobe register bus. It carries a write flag, a word address and 32-bit data. Read data appears on the cycle after the strobe. Over this bus software can set or clear one enable bit by source number, load the enable and type vectors in halves, and overwrite the pending halves. It can also read raw and filtered status. Reading either vector word acknowledges the source it reports by clearing that source's pending bit.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the mask word (1) reads 0x1F. The control word (0) reads 0. Raw status, enable, type and all priority words read 0, and both requests are low.
- R2: A change of source level updates its pending bit to the new level on the clock edge where the change is first seen. Raw status is readable at word 18 (sources 63..32) and word 19 (sources 31..0).
- R3: The fast request is high exactly when some source is pending, enabled and of fast type.
- R4: A write to word 2 sets the enable bit numbered by data bits 5:0. A write to word 3 clears that bit. Both words read back 0.
- R5: Words 4 and 5 hold the enable bits 63..32 and 31..0. Words 6 and 7 hold the type bits in the same split. All four read back what was written.
- R6: A write to word 20 (high) or word 21 (low) replaces that half of the pending vector, and both words read 0. When such a write and a source level change hit the same bit in one cycle, the written value is kept.
- R7: A read of word 17 returns the lowest-numbered source that is pending, enabled and fast, and clears its pending bit. If there is no such source it returns 0xFFFFFFFF.
- R8: A read of word 16 returns (number << 16) | priority for the normal-type, pending, enabled source of highest priority, and clears its pending bit. Among equal priorities the highest number wins. If there is no such source it returns 0xFFFFFFFF.
- R9: The normal request is high when some pending, enabled, normal source has a priority strictly greater than the mask. When the mask is 0x1F, any such source raises the request.
- R10: Priority word 15-k holds the priorities of sources 8k..8k+7. Source i uses bits 4*(i%8)+3 .. 4*(i%8).
- R11: In the control word only bits 24, 22, 21, 20, 19 and 18 are stored (mask 0x017C0000). The mask word stores its low 5 bits.
- R12: Writes to words 16..19 and 22..25, and to words 0x40..0xBF, change no state. A read of word 0x40 returns 4.
- R13: Words 22 and 23 return the normal pending set (pending AND enabled AND NOT type), high and low halves. Words 24 and 25 return the fast set (pending AND enabled AND type) in the same split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 64 | Source levels, one per source |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| nrm_irq | output | 1 | Normal interrupt request |
| fst_irq | output | 1 | Fast interrupt request |

## Verification
The bench goes after the ordering rules of the two vector reads. An arbiter that lets the lower number win a priority tie would return source 2 before 40. One that ignores priority would return source 7 before source 1. A fast picker scanning from the top would report 11 before 9. Repeated vector reads must drain the sources one by one and then return all ones; a design that forgot the acknowledge would return the same source again. It also checks the mask edge: mask 0x1F passes any source, while a mask equal to the only priority present blocks it. A bus write and a source edge are made to collide on one bit, so a design that let the source win would show the bit set. The reversed priority word order is probed through a source in the top word.

// File: rtl/irq_vec_pkg.sv
// Package: word addresses and constants shared by the interrupt controller.
// Assumes a word-addressed bus; addresses below are word numbers.
package irq_vec_pkg;
    localparam int unsigned W_CTRL     = 0;
    localparam int unsigned W_MASK     = 1;
    localparam int unsigned W_ENNUM    = 2;
    localparam int unsigned W_DISNUM   = 3;
    localparam int unsigned W_ENHI     = 4;
    localparam int unsigned W_ENLO     = 5;
    localparam int unsigned W_TYPHI    = 6;
    localparam int unsigned W_TYPLO    = 7;
    localparam int unsigned W_PRIOBASE = 8;
    localparam int unsigned W_NVEC     = 16;
    localparam int unsigned W_FVEC     = 17;
    localparam int unsigned W_RAWHI    = 18;
    localparam int unsigned W_RAWLO    = 19;
    localparam int unsigned W_FRCHI    = 20;
    localparam int unsigned W_FRCLO    = 21;
    localparam int unsigned W_NPHI     = 22;
    localparam int unsigned W_NPLO     = 23;
    localparam int unsigned W_FPHI     = 24;
    localparam int unsigned W_FPLO     = 25;
    localparam int unsigned W_VEC0     = 64;
    localparam int unsigned W_DROP_LO  = 64;
    localparam int unsigned W_DROP_HI  = 191;
    localparam logic [31:0] CTRL_WMASK = 32'h017C_0000;
    localparam logic [31:0] VEC0_VALUE = 32'h0000_0004;
endpackage

// File: rtl/irq_norm_arb.sv
// Normal-path arbiter: picks the highest-priority flagged source, with the
// highest number winning ties, and decides whether the normal request is
// raised against the mask. Purely combinational; assumes MASK_W > PRIO_W.
module irq_norm_arb #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned PRIO_W  = 4,
    parameter int unsigned MASK_W  = 5,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        flags,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [MASK_W-1:0]         mask,
    output logic                      req,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Linear scan: upward order with >= makes higher numbers win ties.
    always_comb begin
        logic above;
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        above    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (flags[i]) begin
                if (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio) begin
                    win_idx  = IDX_W'(i);
                    win_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
                found = 1'b1;
                if (MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > mask) above = 1'b1;
            end
        end
        req = found && (above || (mask == '1));
    end

    // R8
    always_comb begin
        if (found) begin
            win_flagged_chk: assert (flags[win_idx]);
        end
    end
endmodule

// File: rtl/irq_fast_pick.sv
// Fast-path picker: reports the lowest-numbered flagged source.
// Purely combinational; hit is low when no flag is set.
module irq_fast_pick #(
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] flags,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    // Downward scan so the last assignment is the lowest set bit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (flags[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R7
    always_comb begin
        if (hit) begin
            lowest_pick_chk: assert ((flags & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0);
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Dual-output vectored interrupt controller top. Holds pending, enable,
// type, control, mask and priority state and decodes the register bus.
// Assumes NUM_SRC = 2*DATA_W (two halves per vector) and DATA_W = 32.
// Pending bits follow source level changes; vector reads acknowledge.
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned PRIO_W  = 4,
    parameter int unsigned MASK_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               nrm_irq,
    output logic               fst_irq
);
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);
    localparam int unsigned HALF    = NUM_SRC / 2;
    localparam int unsigned PPW     = DATA_W / PRIO_W;
    localparam int unsigned P_WORDS = NUM_SRC / PPW;
    localparam int unsigned P_LAST  = W_PRIOBASE + P_WORDS - 1;
    localparam int unsigned FIELD_W = DATA_W / 2;

    logic [NUM_SRC-1:0]        pend_q, pend_d, en_q, typ_q, src_q;
    logic [DATA_W-1:0]         ctrl_q;
    logic [MASK_W-1:0]         mask_q;
    logic [DATA_W-1:0]         prio_q [P_WORDS];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        live, nflags, fflags;
    logic                      n_req, n_found, f_hit;
    logic [IDX_W-1:0]          n_idx, f_idx;
    logic [PRIO_W-1:0]         n_prio;
    logic                      wr, rd;
    logic [DATA_W-1:0]         rd_val;
    int unsigned               word;

    assign wr   = bus_req && bus_we;
    assign rd   = bus_req && !bus_we;
    assign word = int'(bus_addr);

    // Flatten priority words: source i sits in word i/PPW, nibble i%PPW.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_prio
        assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q[gi / PPW][(gi % PPW)*PRIO_W +: PRIO_W];
    end

    assign live   = pend_q & en_q;
    assign nflags = live & ~typ_q;
    assign fflags = live & typ_q;

    irq_norm_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_arb (
        .flags(nflags), .prio_flat(prio_flat), .mask(mask_q),
        .req(n_req), .found(n_found), .win_idx(n_idx), .win_prio(n_prio)
    );

    irq_fast_pick #(.NUM_SRC(NUM_SRC)) u_fpick (
        .flags(fflags), .hit(f_hit), .idx(f_idx)
    );

    assign nrm_irq = n_req;
    assign fst_irq = f_hit;

    // Next pending: source edges, then read acknowledges, then force writes.
    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i] != src_q[i]) pend_d[i] = src_lvl[i];
        end
        if (rd && word == W_FVEC && f_hit)   pend_d[f_idx] = 1'b0;
        if (rd && word == W_NVEC && n_found) pend_d[n_idx] = 1'b0;
        if (wr && word == W_FRCHI) pend_d[NUM_SRC-1:HALF] = bus_wdata;
        if (wr && word == W_FRCLO) pend_d[HALF-1:0]       = bus_wdata;
    end

    // Read data mux, evaluated against the state before this cycle's update.
    always_comb begin
        rd_val = '0;
        if (word >= W_PRIOBASE && word <= P_LAST) begin
            rd_val = prio_q[P_LAST - word];
        end else begin
            case (word)
                W_CTRL:  rd_val = ctrl_q;
                W_MASK:  rd_val = DATA_W'(mask_q);
                W_ENHI:  rd_val = en_q[NUM_SRC-1:HALF];
                W_ENLO:  rd_val = en_q[HALF-1:0];
                W_TYPHI: rd_val = typ_q[NUM_SRC-1:HALF];
                W_TYPLO: rd_val = typ_q[HALF-1:0];
                W_NVEC:  rd_val = n_found ? {FIELD_W'(n_idx), FIELD_W'(n_prio)} : '1;
                W_FVEC:  rd_val = f_hit ? DATA_W'(f_idx) : '1;
                W_RAWHI: rd_val = pend_q[NUM_SRC-1:HALF];
                W_RAWLO: rd_val = pend_q[HALF-1:0];
                W_NPHI:  rd_val = nflags[NUM_SRC-1:HALF];
                W_NPLO:  rd_val = nflags[HALF-1:0];
                W_FPHI:  rd_val = fflags[NUM_SRC-1:HALF];
                W_FPLO:  rd_val = fflags[HALF-1:0];
                W_VEC0:  rd_val = VEC0_VALUE;
                default: rd_val = '0;
            endcase
        end
    end

    // State registers: reset values, bus writes, pending and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            en_q      <= '0;
            typ_q     <= '0;
            src_q     <= '0;
            ctrl_q    <= '0;
            mask_q    <= '1;
            bus_rdata <= '0;
            for (int k = 0; k < P_WORDS; k++) prio_q[k] <= '0;
        end else begin
            src_q  <= src_lvl;
            pend_q <= pend_d;
            if (rd) bus_rdata <= rd_val;
            if (wr) begin
                if (word >= W_PRIOBASE && word <= P_LAST) prio_q[P_LAST - word] <= bus_wdata;
                case (word)
                    W_CTRL:   ctrl_q <= bus_wdata & CTRL_WMASK;
                    W_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
                    W_ENNUM:  en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
                    W_DISNUM: en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
                    W_ENHI:   en_q[NUM_SRC-1:HALF]  <= bus_wdata;
                    W_ENLO:   en_q[HALF-1:0]        <= bus_wdata;
                    W_TYPHI:  typ_q[NUM_SRC-1:HALF] <= bus_wdata;
                    W_TYPLO:  typ_q[HALF-1:0]       <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_q == '1 && pend_q == '0 && ctrl_q == '0 && en_q == '0));

    // R4
    enable_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == W_ENNUM) |=> en_q[$past(bus_wdata[IDX_W-1:0])]);

    // R7
    fast_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && word == W_FVEC && f_hit) |=> !pend_q[$past(f_idx)]);

    // R12
    readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ((word >= W_NVEC && word <= W_RAWLO) || (word >= W_DROP_LO && word <= W_DROP_HI)))
        |=> ($stable(en_q) && $stable(typ_q) && $stable(ctrl_q) && $stable(mask_q)));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_lvl = '0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nrm_irq, fst_irq;
    int          checks = 0, failures = 0, cyc = 0;
    bit          done = 1'b0;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nrm_irq(nrm_irq), .fst_irq(fst_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 10'(a);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 mask", 1, 32'h1F);
        rd_chk("R1 ctrl", 0, 32'h0);
        rd_chk("R1 raw", 19, 32'h0);
        rd_chk("R1 enable", 5, 32'h0);
        rd_chk("R1 prio", 15, 32'h0);
        chk("R1 nrm_irq", 32'(nrm_irq), 32'h0);
        chk("R1 fst_irq", 32'(fst_irq), 32'h0);
    endtask

    task automatic t_ctrl();
        wr(0, 32'hFFFF_FFFF);
        rd_chk("R11 ctrl bits", 0, 32'h017C_0000);
        wr(1, 32'hFFFF_FFE3);
        rd_chk("R11 mask bits", 1, 32'h03);
        wr(1, 32'h1F);
    endtask

    task automatic t_enable_num();
        wr(2, 32'h45);
        rd_chk("R4 enable 5", 5, 32'h20);
        wr(2, 32'd40);
        rd_chk("R4 enable 40", 4, 32'h100);
        rd_chk("R4 read ennum", 2, 32'h0);
        wr(3, 32'hC5);
        rd_chk("R4 disable 5", 5, 32'h0);
        rd_chk("R4 read disnum", 3, 32'h0);
    endtask

    task automatic t_halves();
        wr(5, 32'hDEAD_BEEF);
        wr(4, 32'h1234_5678);
        rd_chk("R5 en lo", 5, 32'hDEAD_BEEF);
        rd_chk("R5 en hi", 4, 32'h1234_5678);
        wr(7, 32'hA5A5_A5A5);
        rd_chk("R5 typ lo", 7, 32'hA5A5_A5A5);
        rd_chk("R5 typ hi", 6, 32'h0);
        wr(4, 32'h0); wr(5, 32'h0); wr(7, 32'h0);
    endtask

    task automatic t_source();
        @(negedge clk);
        src_lvl[3] = 1'b1; src_lvl[40] = 1'b1;
        rd_chk("R2 raw lo set", 19, 32'h8);
        rd_chk("R2 raw hi set", 18, 32'h100);
        @(negedge clk);
        src_lvl[3] = 1'b0;
        rd_chk("R2 raw lo clear", 19, 32'h0);
    endtask

    task automatic t_fast();
        wr(5, 32'hFFFF_FFFF);
        wr(4, 32'hFFFF_FFFF);
        wr(7, 32'h0000_0F00);
        wr(21, 32'h0000_0A00);
        chk("R3 fst_irq high", 32'(fst_irq), 32'h1);
        rd_chk("R13 fast pend lo", 25, 32'h0000_0A00);
        rd_chk("R13 norm pend lo", 23, 32'h0);
        rd_chk("R13 norm pend hi", 22, 32'h100);
        rd_chk("R6 force read", 21, 32'h0);
        rd_chk("R7 first", 17, 32'd9);
        rd_chk("R7 second", 17, 32'd11);
        rd_chk("R7 empty", 17, 32'hFFFF_FFFF);
        chk("R3 fst_irq low", 32'(fst_irq), 32'h0);
    endtask

    task automatic t_normal();
        wr(7, 32'h0);
        wr(10, 32'h0000_0003);
        wr(15, 32'h0300_0300);
        wr(21, 32'h0000_0044);
        chk("R9 mask 1F any", 32'(nrm_irq), 32'h1);
        wr(1, 32'h3);
        chk("R9 mask equal blocks", 32'(nrm_irq), 32'h0);
        wr(1, 32'h2);
        chk("R9 mask below passes", 32'(nrm_irq), 32'h1);
        rd_chk("R10 prio word 15", 15, 32'h0300_0300);
        rd_chk("R10 prio word 10", 10, 32'h3);
        rd_chk("R8 tie high num", 16, 32'h0028_0003);
        rd_chk("R8 tie next", 16, 32'h0006_0003);
        rd_chk("R8 tie last", 16, 32'h0002_0003);
        rd_chk("R8 empty", 16, 32'hFFFF_FFFF);
        chk("R9 drained", 32'(nrm_irq), 32'h0);
        wr(15, 32'h2000_0050);
        wr(21, 32'h0000_0082);
        rd_chk("R8 higher prio", 16, 32'h0001_0005);
        rd_chk("R8 lower prio", 16, 32'h0007_0002);
        wr(8, 32'hF000_0000);
        wr(20, 32'h8000_0000);
        rd_chk("R10 reversed word 8", 16, 32'h003F_000F);
        wr(1, 32'h1F);
    endtask

    task automatic t_rdonly();
        wr(19, 32'hFFFF_FFFF);
        wr(23, 32'hFFFF_FFFF);
        wr(16, 32'hFFFF_FFFF);
        rd_chk("R12 raw unchanged", 19, 32'h0);
        wr(64, 32'h0);
        wr(191, 32'h0);
        rd_chk("R12 dropped keeps enable", 5, 32'hFFFF_FFFF);
        rd_chk("R12 vec0", 64, 32'h4);
    endtask

    task automatic t_collide();
        @(negedge clk);
        src_lvl[13] = 1'b1;
        rd_chk("R2 edge sets", 19, 32'h0000_2000);
        @(negedge clk);
        src_lvl[12] = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'd21; bus_wdata = 32'h0;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        rd_chk("R6 bus wins", 19, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_enable_num();
        t_halves();
        t_source();
        t_fast();
        t_normal();
        t_rdonly();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule